// File: doc/BRIEF.md
# Configurable Booth Multiplier

This block is a hard multiplier tile for a programmable fabric. It takes two operands of `WIDTH` bits, 18 by default, and returns their full `2*WIDTH`-bit product. A mode input picks the interpretation of the operands. In signed mode both operands are two's complement. In unsigned mode the top bit of each operand is dropped, so the block multiplies two `WIDTH-1`-bit magnitudes on the same datapath.

Radix-4 Booth recoding of the `b` operand cuts the number of partial-product rows to about half the operand width. Carry-save 3:2 compression folds the rows into a sum vector and a carry vector. A grouped carry-lookahead adder then resolves those two vectors into the product. A timing field selects one of three output behaviours:

- a purely combinational path;
- one output register;
- two register stages, with one cut between the compression and the final adder.

The timing and mode settings are meant to be static. After either one changes, the output is undefined until the registers have refilled.

Top module: `booth_mult`

## Requirements
- R1: With `signed_i`=1, `p_o` equals the two's complement product of `a_i` and `b_i`, taken as signed `WIDTH`-bit values, over all `2*WIDTH` bits.
- R2: With `signed_i`=0, bit `WIDTH-1` of each operand is ignored. `p_o` equals the unsigned product of the low `WIDTH-1` bits, and its two top bits are 0.
- R3: The Booth rows together with their negation-correction ones add up to the exact product for every operand pair, including the most negative value times itself.
- R4: With `timing_i`=0 the product appears at `p_o` combinationally, with no clock edge between a change of operands and the new result.
- R5: With `timing_i`=1 the operands sampled at a rising edge produce their product at `p_o` just after that edge. `p_o` then holds that value until the next edge, whatever the operands do in between.
- R6: With `timing_i`=2 or 3 the product of operands sampled at edge k appears at `p_o` just after edge k+1, giving two register stages.
- R7: While `rst_ni` is low, all registers are cleared at once without a clock, so `p_o` reads 0 when `timing_i` is 1, 2 or 3.
- R8: The final adder gives the exact sum, including the carry out, of the compressed sum and carry vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output and pipeline registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| signed_i | input | 1 | 1: signed WIDTH x WIDTH; 0: unsigned (WIDTH-1) x (WIDTH-1) |
| timing_i | input | 2 | 0 combinational, 1 registered, 2 or 3 two-stage pipeline |
| a_i | input | WIDTH | Multiplicand |
| b_i | input | WIDTH | Multiplier, the operand that is Booth-recoded |
| p_o | output | 2*WIDTH | Product |

## Verification
The assertions recheck several properties at every clock edge:

- in the combinational setting, the product in both modes;
- in the two registered settings, the one-edge and two-edge latency, measured against operands seen earlier;
- that the Booth rows sum to the exact product;
- that the lookahead adder agrees with a plain addition.

Other behaviour shows only in the bench's scenarios:

- that the registered output ignores operand changes between edges;
- that reset clears the output asynchronously in the middle of operation;
- that the unsigned mode ignores a set top bit;
- that timing code 3 acts as the pipeline.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    TM_COMB     = 2'd0,
    TM_REG      = 2'd1,
    TM_PIPE     = 2'd2,
    TM_PIPE_ALT = 2'd3
  } timing_e;

  localparam int unsigned CLA_GROUP = 4;

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int unsigned WIDTH = 18,
  localparam int unsigned PW   = 2 * WIDTH,
  localparam int unsigned NG   = (WIDTH + 1) / 2
) (
  input  logic [WIDTH-1:0]        a_i,
  input  logic [WIDTH-1:0]        b_i,
  output logic [NG-1:0][PW-1:0]   rows_o,
  output logic [NG-1:0]           neg_o
);

  // b with an implicit zero below bit 0, sign-extended up to bit 2*NG
  logic [2*NG:0] b_ext;
  logic [PW-1:0] a_x1, a_x2;

  always_comb begin
    b_ext = '0;
    b_ext[WIDTH:1] = b_i;
    for (int k = WIDTH + 1; k <= 2 * NG; k++) b_ext[k] = b_i[WIDTH-1];
  end

  assign a_x1 = {{WIDTH{a_i[WIDTH-1]}}, a_i};
  assign a_x2 = a_x1 << 1;

  for (genvar i = 0; i < NG; i++) begin : g_row
    logic [2:0]    grp;
    logic          sel_one, sel_two, neg;
    logic [PW-1:0] mag;

    assign grp = b_ext[2*i+2 -: 3];

    always_comb begin
      sel_one = 1'b0;
      sel_two = 1'b0;
      neg     = 1'b0;
      unique case (grp)
        3'b001, 3'b010: sel_one = 1'b1;
        3'b011:         sel_two = 1'b1;
        3'b100:         begin sel_two = 1'b1; neg = 1'b1; end
        3'b101, 3'b110: begin sel_one = 1'b1; neg = 1'b1; end
        default:        ;
      endcase
    end

    assign mag       = sel_two ? a_x2 : (sel_one ? a_x1 : '0);
    // negative row: inverted multiple, +1 correction added by the reducer
    assign rows_o[i] = (neg ? ~mag : mag) << (2 * i);
    assign neg_o[i]  = neg;
  end

endmodule

// File: rtl/booth_csa_reduce.sv
module booth_csa_reduce #(
  parameter int unsigned WIDTH = 18,
  localparam int unsigned PW   = 2 * WIDTH,
  localparam int unsigned NG   = (WIDTH + 1) / 2
) (
  input  logic [NG-1:0][PW-1:0] rows_i,
  input  logic [NG-1:0]         neg_i,
  output logic [PW-1:0]         sum_o,
  output logic [PW-1:0]         carry_o
);

  always_comb begin
    logic [PW-1:0] s, c, t;
    s = '0;
    // correction ones for negated rows seed the sum vector
    for (int i = 0; i < NG; i++) s[2*i] = neg_i[i];
    c = '0;
    for (int i = 0; i < NG; i++) begin
      t = s ^ c ^ rows_i[i];
      c = ((s & c) | (s & rows_i[i]) | (c & rows_i[i])) << 1;
      s = t;
    end
    sum_o   = s;
    carry_o = c;
  end

endmodule

// File: rtl/booth_cla_adder.sv
module booth_cla_adder
  import booth_pkg::*;
#(
  parameter int unsigned N    = 36,
  localparam int unsigned GS   = CLA_GROUP,
  localparam int unsigned NGRP = (N + GS - 1) / GS,
  localparam int unsigned NP   = NGRP * GS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] sum_o
);

  logic [NP-1:0]   xp, yp, gb, pb, cb, sp;
  logic [NGRP-1:0] gg, gp;
  logic [NGRP:0]   gc;

  always_comb begin
    xp = '0;
    yp = '0;
    xp[N-1:0] = x_i;
    yp[N-1:0] = y_i;
  end

  assign gb = xp & yp;
  assign pb = xp ^ yp;

  always_comb begin
    logic c;
    // group generate / propagate
    for (int j = 0; j < NGRP; j++) begin
      gg[j] = 1'b0;
      gp[j] = 1'b1;
      for (int k = 0; k < GS; k++) begin
        gg[j] = gb[j*GS+k] | (pb[j*GS+k] & gg[j]);
        gp[j] = gp[j] & pb[j*GS+k];
      end
    end
    // group carries, then in-group carries
    gc[0] = 1'b0;
    for (int j = 0; j < NGRP; j++) gc[j+1] = gg[j] | (gp[j] & gc[j]);
    for (int j = 0; j < NGRP; j++) begin
      c = gc[j];
      for (int k = 0; k < GS; k++) begin
        cb[j*GS+k] = c;
        c = gb[j*GS+k] | (pb[j*GS+k] & c);
      end
    end
  end

  assign sp    = pb ^ cb;
  assign sum_o = sp[N-1:0];

  p_cla_sum_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {gc[NGRP], sp} == ({1'b0, xp} + {1'b0, yp}));

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               signed_i,
  input  logic [1:0]         timing_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] p_o
);

  localparam int unsigned PW = 2 * WIDTH;
  localparam int unsigned NG = (WIDTH + 1) / 2;

  timing_e              tm;
  logic                 pipe_sel;
  logic [WIDTH-1:0]     a_op, b_op;
  logic [NG-1:0][PW-1:0] rows;
  logic [NG-1:0]        neg;
  logic [PW-1:0]        sum_c, carry_c, sum_q, carry_q;
  logic [PW-1:0]        add_x, add_y, add_s, out_q;

  assign tm       = timing_e'(timing_i);
  assign pipe_sel = (tm == TM_PIPE) || (tm == TM_PIPE_ALT);

  // unsigned mode: clear the top bit so the signed datapath sees a magnitude
  assign a_op = signed_i ? a_i : {1'b0, a_i[WIDTH-2:0]};
  assign b_op = signed_i ? b_i : {1'b0, b_i[WIDTH-2:0]};

  booth_pp_gen #(.WIDTH(WIDTH)) u_pp_gen (
    .a_i    (a_op),
    .b_i    (b_op),
    .rows_o (rows),
    .neg_o  (neg)
  );

  booth_csa_reduce #(.WIDTH(WIDTH)) u_reduce (
    .rows_i  (rows),
    .neg_i   (neg),
    .sum_o   (sum_c),
    .carry_o (carry_c)
  );

  // first pipeline cut: between compression and final adder
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else begin
      sum_q   <= sum_c;
      carry_q <= carry_c;
    end
  end

  assign add_x = pipe_sel ? sum_q   : sum_c;
  assign add_y = pipe_sel ? carry_q : carry_c;

  booth_cla_adder #(.N(PW)) u_cla (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (add_x),
    .y_i    (add_y),
    .sum_o  (add_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= add_s;
  end

  assign p_o = (tm == TM_COMB) ? add_s : out_q;

  // ---------------- checks ----------------
  logic [1:0]    live_q;
  logic [PW-1:0] sa, sb, ua, ub, ref_w, pp_total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              live_q <= '0;
    else if (live_q != 2'd3)  live_q <= live_q + 2'd1;
  end

  always_comb begin
    sa = {{WIDTH{a_i[WIDTH-1]}}, a_i};
    sb = {{WIDTH{b_i[WIDTH-1]}}, b_i};
    ua = '0;
    ub = '0;
    ua[WIDTH-2:0] = a_i[WIDTH-2:0];
    ub[WIDTH-2:0] = b_i[WIDTH-2:0];
    ref_w = signed_i ? PW'($signed(sa) * $signed(sb)) : PW'(ua * ub);
  end

  always_comb begin
    pp_total = '0;
    for (int i = 0; i < NG; i++)
      pp_total = pp_total + rows[i] + (PW'(neg[i]) << (2 * i));
  end

  p_booth_rows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_total == ref_w);

  p_signed_comb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm == TM_COMB && signed_i) |-> p_o == ref_w);

  p_unsigned_comb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm == TM_COMB && !signed_i) |-> (p_o == ref_w && p_o[PW-1:PW-2] == 2'b00));

  p_reg_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm == TM_REG && $past(tm) == TM_REG && live_q >= 2'd1) |-> p_o == $past(ref_w));

  p_pipe_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_sel && ($past(timing_i) >= 2'd2) && live_q >= 2'd2) |-> p_o == $past(ref_w, 2));

endmodule

// File: tb/booth_mult_bench.sv
module booth_mult_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // {signed, a, b}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 18'h00005, 18'h00007},
    {1'b1, 18'h3FFFF, 18'h3FFFF},
    {1'b1, 18'h20000, 18'h20000},
    {1'b1, 18'h1FFFF, 18'h20000},
    {1'b1, 18'h3FFFD, 18'h03039},
    {1'b1, 18'h2AAAA, 18'h15555},
    {1'b0, 18'h1FFFF, 18'h1FFFF},
    {1'b0, 18'h3FFFF, 18'h3FFFF},
    {1'b0, 18'h20001, 18'h00003},
    {1'b0, 18'h03039, 18'h002A6}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        signed_i;
  logic [1:0]  timing_i;
  logic [17:0] a_i, b_i;
  logic [35:0] p_o;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  booth_mult #(.WIDTH(18)) u_booth_mult (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .signed_i (signed_i),
    .timing_i (timing_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .p_o      (p_o)
  );

  function automatic logic [35:0] model(input logic s, input logic [17:0] a, input logic [17:0] b);
    logic signed [35:0] sa, sb;
    logic [35:0] ua, ub;
    sa = {{18{a[17]}}, a};
    sb = {{18{b[17]}}, b};
    ua = {19'b0, a[16:0]};
    ub = {19'b0, b[16:0]};
    return s ? 36'(sa * sb) : 36'(ua * ub);
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input int i);
    signed_i = VEC[i][36];
    a_i      = VEC[i][35:18];
    b_i      = VEC[i][17:0];
  endtask

  initial begin
    rst_ni   = 1'b0;
    timing_i = 2'd1;
    apply(0);
    repeat (3) @(negedge clk);
    check("R7 reset reg mode", p_o, 36'd0);
    timing_i = 2'd2;
    #1 check("R7 reset pipe mode", p_o, 36'd0);
    @(negedge clk) rst_ni = 1'b1;

    // combinational: R1/R2 products, R3 Booth rows, R4 no clock, R8 final add
    timing_i = 2'd0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(i);
      #1;
      check(VEC[i][36] ? "R1 R3 R4 R8 comb" : "R2 R3 R4 R8 comb", p_o, model(VEC[i][36], VEC[i][35:18], VEC[i][17:0]));
      if (!VEC[i][36]) check("R2 top bits zero", {34'd0, p_o[35:34]}, 36'd0);
    end

    // registered: one edge latency, held between edges
    @(negedge clk) timing_i = 2'd1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(i);
      @(posedge clk);
      #1 check("R5 registered", p_o, model(VEC[i][36], VEC[i][35:18], VEC[i][17:0]));
      a_i = ~a_i;
      b_i = b_i + 18'd1;
      #1 check("R5 hold between edges", p_o, model(VEC[i][36], VEC[i][35:18], VEC[i][17:0]));
    end

    // two-stage pipeline streaming
    @(negedge clk) timing_i = 2'd2;
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check("R6 pipelined", p_o, model(VEC[i-2][36], VEC[i-2][35:18], VEC[i-2][17:0]));
      if (i < NV) apply(i);
      else begin a_i = '0; b_i = '0; end
    end

    // timing code 3 behaves as pipeline
    @(negedge clk);
    timing_i = 2'd3;
    apply(5);
    @(posedge clk);
    @(negedge clk);
    a_i = '0;
    @(posedge clk);
    #1 check("R6 alt code", p_o, model(VEC[5][36], VEC[5][35:18], VEC[5][17:0]));

    // asynchronous reset mid-run
    @(negedge clk);
    timing_i = 2'd1;
    apply(1);
    @(posedge clk);
    #1 check("R5 before reset", p_o, 36'd1);
    #1 rst_ni = 1'b0;
    #1 check("R7 async clear", p_o, 36'd0);
    @(negedge clk) rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule